// File: doc/BRIEF.md
# Streaming Register Front End for a Matrix Accelerator

This block is the bus-facing side of a small matrix accelerator on a microcontroller peripheral bus. Software sees four 32-bit words. It writes the operand matrix sizes and then sets an enable bit. From that point a DMA engine streams the input matrix and then the weight matrix into one fixed data address. Internal counters place every word at the next buffer location, so the block needs no large address window.

When both operand buffers are full, the block sends a one-cycle start to the compute array. When the array reports completion, the block raises a done flag and rewinds its output read pointer. Software or DMA then drains the results by reading the same data address over and over. Each read returns the next output entry.

The compute array and its buffers sit outside this block. The block reaches them through buffer write strobes with a shared address, an output-buffer read address, and start/done lines. All bus accesses take one cycle. Read data comes back combinationally in the cycle of the access.

Top module: `mxacc_regfront`

## Requirements
- R1: A synchronous active-low reset clears both size registers, the control state, the done flag, both pointers, `dma_req` and `arr_start`. After reset, reads of word 0, word 1 and word 2 all return 0.
- R2: Word 1 holds the input size and word 2 holds the weight size. In each, bits 31:16 are the row count and bits 15:0 are the column count. Both read back as written and drive `arr_isize` and `arr_wsize`. A write to either word is ignored while an operation is in progress.
- R3: Word 0 is the control word. Bit 0 is the enable bit: writing 1 to it starts an operation, and it reads 1 until the operation ends. Bit 1 selects the operation (0 = fully connected, 1 = convolution); it is captured by the accepted enable write and drives `arr_op`. Bit 2 is a read-only done flag.
- R4: `dma_req` is high from the cycle after an accepted enable until the last weight word has been accepted. It is low at all other times.
- R5: A write to word 3 during loading goes to the input buffer (`ibuf_we`) at addresses 0, 1, … until rows×columns words have been taken. Later writes go to the weight buffer (`wbuf_we`), again starting at address 0. A write to word 3 while the block is not loading asserts neither strobe.
- R6: `arr_start` is high for exactly one cycle: the cycle right after the clock edge that accepts the last weight word.
- R7: `arr_done` during the compute phase ends the operation on the next edge. The done flag sets, the enable bit reads 0, and the output read pointer returns to 0. The done flag clears on the next accepted enable write.
- R8: A read of word 3 returns `obuf_rdata`, the output entry at `obuf_raddr`, which equals the read pointer. Each such read then advances the pointer by one.
- R9: A write of 1 to the enable bit while an operation is in progress is ignored. It changes neither the stored operation type nor the sequence.
- R10: If an operand size has a zero product, its load phase is skipped. If both products are zero, `arr_start` pulses in the cycle right after the enable write and `dma_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (0 control, 1 input size, 2 weight size, 3 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| dma_req | output | 1 | Request for operand words |
| ibuf_we | output | 1 | Input buffer write strobe |
| wbuf_we | output | 1 | Weight buffer write strobe |
| buf_waddr | output | PTR_W | Operand buffer write address |
| buf_wdata | output | 32 | Operand buffer write data |
| obuf_raddr | output | PTR_W | Output buffer read address |
| obuf_rdata | input | 32 | Output buffer read data |
| arr_start | output | 1 | One-cycle start to compute array |
| arr_op | output | 1 | Operation type to compute array |
| arr_isize | output | 32 | Input size word to compute array |
| arr_wsize | output | 32 | Weight size word to compute array |
| arr_done | input | 1 | Completion from compute array |

## Verification
The bench checks the hand-over from the input phase to the weight phase. A design that spends one idle cycle at the hand-over drops the first weight word; one that forgets to rewind the write pointer puts weights at the wrong address. It also checks an enable or size write issued mid-load. A careless design would restart the fill or change the operation type under the array. Zero-sized operands are covered as well. Here an off-by-one comparison would hang waiting for a word that never comes, or would start the array too late. Finally the bench reads the output stream before and after done, which exposes a pointer that is not rewound when done arrives.

// File: rtl/mxacc_regfront.sv
module mxacc_regfront #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             dma_req,
  output logic             ibuf_we,
  output logic             wbuf_we,
  output logic [PTR_W-1:0] buf_waddr,
  output logic [31:0]      buf_wdata,
  output logic [PTR_W-1:0] obuf_raddr,
  input  logic [31:0]      obuf_rdata,
  output logic             arr_start,
  output logic             arr_op,
  output logic [31:0]      arr_isize,
  output logic [31:0]      arr_wsize,
  input  logic             arr_done
);

  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_ISZ  = 2'd1;
  localparam logic [1:0] W_WSZ  = 2'd2;
  localparam logic [1:0] W_DATA = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LDI, S_LDW, S_RUN} st_t;

  st_t              st;
  logic [31:0]      isize_q, wsize_q, fill_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             op_q, done_q, start_q;

  logic wr_ctrl, wr_isz, wr_wsz, wr_data, rd_data, go;
  logic [31:0] in_total, w_total;
  logic in_last, w_last;

  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == W_CTRL);
  assign wr_isz  = bus_sel &  bus_wr & (bus_addr == W_ISZ);
  assign wr_wsz  = bus_sel &  bus_wr & (bus_addr == W_WSZ);
  assign wr_data = bus_sel &  bus_wr & (bus_addr == W_DATA);
  assign rd_data = bus_sel & ~bus_wr & (bus_addr == W_DATA);
  assign go      = wr_ctrl & bus_wdata[0] & (st == S_IDLE);

  assign in_total = 32'(isize_q[31:16]) * 32'(isize_q[15:0]);
  assign w_total  = 32'(wsize_q[31:16]) * 32'(wsize_q[15:0]);
  assign in_last  = (fill_ptr == in_total - 32'd1);
  assign w_last   = (fill_ptr == w_total - 32'd1);

  assign dma_req    = (st == S_LDI) || (st == S_LDW);
  assign ibuf_we    = wr_data && (st == S_LDI);
  assign wbuf_we    = wr_data && (st == S_LDW);
  assign buf_waddr  = fill_ptr[PTR_W-1:0];
  assign buf_wdata  = bus_wdata;
  assign obuf_raddr = rd_ptr;
  assign arr_start  = start_q;
  assign arr_op     = op_q;
  assign arr_isize  = isize_q;
  assign arr_wsize  = wsize_q;

  always_comb begin
    case (bus_addr)
      W_CTRL:  bus_rdata = {29'd0, done_q, op_q, st != S_IDLE};
      W_ISZ:   bus_rdata = isize_q;
      W_WSZ:   bus_rdata = wsize_q;
      default: bus_rdata = obuf_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      isize_q  <= '0;
      wsize_q  <= '0;
      fill_ptr <= '0;
      rd_ptr   <= '0;
      op_q     <= 1'b0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (st == S_IDLE && wr_isz) isize_q <= bus_wdata;
      if (st == S_IDLE && wr_wsz) wsize_q <= bus_wdata;
      if (rd_data) rd_ptr <= rd_ptr + 1'b1;
      case (st)
        S_IDLE: if (go) begin
          op_q     <= bus_wdata[1];
          done_q   <= 1'b0;
          fill_ptr <= '0;
          if (in_total != 0)     st <= S_LDI;
          else if (w_total != 0) st <= S_LDW;
          else begin
            st      <= S_RUN;
            start_q <= 1'b1;
          end
        end
        S_LDI: if (ibuf_we) begin
          if (in_last) begin
            fill_ptr <= '0;
            if (w_total != 0) st <= S_LDW;
            else begin
              st      <= S_RUN;
              start_q <= 1'b1;
            end
          end else fill_ptr <= fill_ptr + 32'd1;
        end
        S_LDW: if (wbuf_we) begin
          if (w_last) begin
            st      <= S_RUN;
            start_q <= 1'b1;
          end else fill_ptr <= fill_ptr + 32'd1;
        end
        default: if (arr_done) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          rd_ptr <= '0;
        end
      endcase
    end
  end

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);

  p_we_under_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ibuf_we || wbuf_we) |-> dma_req);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ibuf_we) && ibuf_we) |-> (buf_waddr == $past(buf_waddr) + 1'b1));

  p_sizes_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(isize_q) && $stable(wsize_q)));

  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && arr_done) |=> (done_q && st == S_IDLE && rd_ptr == '0));

  p_no_req_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> !dma_req);

  p_op_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(op_q));

endmodule

// File: tb/sim_mxacc_regfront.sv
module sim_mxacc_regfront;
  localparam int PTR_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dma_req, ibuf_we, wbuf_we, arr_start, arr_op;
  logic [PTR_W-1:0] buf_waddr, obuf_raddr;
  logic [31:0] buf_wdata, obuf_rdata, arr_isize, arr_wsize;
  logic arr_done = 1'b0;

  always #10 clk = ~clk;

  assign obuf_rdata = 32'hC0DE_0000 | 32'(obuf_raddr);

  mxacc_regfront #(.PTR_W(PTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .ibuf_we(ibuf_we), .wbuf_we(wbuf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .obuf_raddr(obuf_raddr),
    .obuf_rdata(obuf_rdata), .arr_start(arr_start), .arr_op(arr_op),
    .arr_isize(arr_isize), .arr_wsize(arr_wsize), .arr_done(arr_done));

  // {op, in rows, in cols, w rows, w cols}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 8'd1, 8'd3, 8'd3, 8'd2},
    {1'b1, 8'd2, 8'd2, 8'd1, 8'd4},
    {1'b0, 8'd4, 8'd1, 8'd2, 8'd2},
    {1'b1, 8'd1, 8'd1, 8'd1, 8'd1}
  };

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd, wd;
  logic iw, ww;
  logic [PTR_W-1:0] wa;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #2;
    rd = bus_rdata; iw = ibuf_we; ww = wbuf_we; wa = buf_waddr; wd = buf_wdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    arr_done = 1'b1;
    @(posedge clk); @(negedge clk);
    arr_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(0, 2'd0, 0); chk("R1 ctrl after reset", rd, 0);
    cyc(0, 2'd1, 0); chk("R1 isize after reset", rd, 0);
    cyc(0, 2'd2, 0); chk("R1 wsize after reset", rd, 0);
    chk("R1 dma_req after reset", 32'(dma_req), 0);
    chk("R1 arr_start after reset", 32'(arr_start), 0);

    cyc(1, 2'd3, 32'h55); chk("R5 idle write no input strobe", 32'(iw), 0);
    chk("R5 idle write no weight strobe", 32'(ww), 0);

    for (int v = 0; v < 4; v++) begin
      logic [32:0] e;
      int ir, ic, wr_, wc, nin, nw;
      logic op;
      e = VEC[v];
      op = e[32]; ir = int'(e[31:24]); ic = int'(e[23:16]);
      wr_ = int'(e[15:8]); wc = int'(e[7:0]);
      nin = ir * ic; nw = wr_ * wc;
      cyc(1, 2'd1, {16'(ir), 16'(ic)});
      cyc(1, 2'd2, {16'(wr_), 16'(wc)});
      cyc(0, 2'd1, 0); chk("R2 isize readback", rd, {16'(ir), 16'(ic)});
      cyc(1, 2'd0, {30'd0, op, 1'b1});
      chk("R4 req after enable", 32'(dma_req), 1);
      cyc(0, 2'd0, 0);
      chk("R3 ctrl busy and op, R7 done cleared", rd, {29'd0, 1'b0, op, 1'b1});
      chk("R3 arr_op", 32'(arr_op), 32'(op));
      chk("R2 arr_wsize", arr_wsize, {16'(wr_), 16'(wc)});
      for (int i = 0; i < nin; i++) begin
        cyc(1, 2'd3, 32'h1000_0000 + 32'(v * 256 + i));
        chk("R5 input strobe", 32'(iw), 1);
        chk("R5 no weight strobe in input phase", 32'(ww), 0);
        chk("R5 input address", 32'(wa), 32'(i));
        chk("R5 input data", wd, 32'h1000_0000 + 32'(v * 256 + i));
      end
      for (int i = 0; i < nw; i++) begin
        chk("R4 req during weight phase", 32'(dma_req), 1);
        cyc(1, 2'd3, 32'h2000_0000 + 32'(i));
        chk("R5 weight strobe", 32'(ww), 1);
        chk("R5 no input strobe in weight phase", 32'(iw), 0);
        chk("R5 weight address", 32'(wa), 32'(i));
      end
      chk("R6 start after last weight", 32'(arr_start), 1);
      chk("R4 req dropped", 32'(dma_req), 0);
      cyc(1, 2'd3, 32'hDEAD);
      chk("R5 run write ignored", 32'(iw | ww), 0);
      chk("R6 start single cycle", 32'(arr_start), 0);
      pulse_done();
      cyc(0, 2'd0, 0); chk("R7 done set enable clear", rd, {29'd0, 1'b1, op, 1'b0});
      for (int i = 0; i < 3; i++) begin
        cyc(0, 2'd3, 0); chk("R8 output stream", rd, 32'hC0DE_0000 | 32'(i));
      end
    end

    // R9 and R2: writes while busy
    cyc(1, 2'd1, 32'h0001_0002);
    cyc(1, 2'd2, 32'h0001_0001);
    cyc(1, 2'd0, 32'h1);
    cyc(1, 2'd0, 32'h3);
    cyc(0, 2'd0, 0); chk("R9 enable while busy ignored", rd, 32'h1);
    cyc(1, 2'd1, 32'h0007_0007);
    cyc(0, 2'd1, 0); chk("R2 size write while busy ignored", rd, 32'h0001_0002);
    cyc(1, 2'd3, 32'hA0); chk("R9 fill not restarted", 32'(wa), 0);
    cyc(1, 2'd3, 32'hA1); chk("R9 second input word", 32'(iw), 1);
    cyc(1, 2'd3, 32'hB0); chk("R5 first weight after hand-over", 32'(ww), 1);
    chk("R5 weight address after hand-over", 32'(wa), 0);
    chk("R6 start", 32'(arr_start), 1);
    cyc(0, 2'd3, 0); cyc(0, 2'd3, 0);
    pulse_done();
    cyc(0, 2'd3, 0); chk("R7 read pointer rewound", rd, 32'hC0DE_0000);
    cyc(0, 2'd3, 0); chk("R8 pointer advances", rd, 32'hC0DE_0001);

    // R10 zero-size operands
    cyc(1, 2'd1, 32'h0000_0005);
    cyc(1, 2'd2, 32'h0001_0002);
    cyc(1, 2'd0, 32'h1);
    chk("R10 req for weights only", 32'(dma_req), 1);
    cyc(1, 2'd3, 32'hC0); chk("R10 skip to weight buffer", 32'(ww), 1);
    chk("R10 no input strobe", 32'(iw), 0);
    cyc(1, 2'd3, 32'hC1);
    chk("R10 start after weights", 32'(arr_start), 1);
    @(negedge clk);
    pulse_done();
    cyc(1, 2'd1, 32'h0);
    cyc(1, 2'd2, 32'h0003_0000);
    cyc(1, 2'd0, 32'h1);
    chk("R10 immediate start", 32'(arr_start), 1);
    chk("R10 no request", 32'(dma_req), 0);
    pulse_done();

    // R1 reset mid-load
    cyc(1, 2'd1, 32'h0002_0002);
    cyc(1, 2'd0, 32'h1);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset drops req", 32'(dma_req), 0);
    cyc(0, 2'd1, 0); chk("R1 reset clears size", rd, 0);
    cyc(0, 2'd0, 0); chk("R1 reset clears ctrl", rd, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule